// File: doc/BRIEF.md
# Extended Opcode Page Decoder

This block decodes the second byte of the prefixed extended opcode page of an 8-bit CPU. Every one of the 256 possible byte values is mapped to a micro-operation class, along with the operand selectors that the execution datapath needs. Unassigned codes do not trap. Each one resolves to a fixed, repeatable result: a no-operation, or an alias of negate, of the two interrupt-return forms, or of interrupt-mode selection. Two codes in the port-I/O column need special handling. One performs an input that updates only the flags. The other drives a constant onto the port, and the value of that constant depends on the process variant chosen at elaboration.

The decoder is purely combinational. The sequencer presents the byte that follows the prefix and reads the class and controls within the same cycle. Internally, a row decoder handles the 0x40–0x7F quadrant, a block decoder handles the 0x80–0xBF quadrant, and a port-special unit handles the flag-only input and the constant output. The top module selects between these by quadrant. The quadrant selection works as a fixed three-way choice: outer quadrants give NOP, 0x40–0x7F goes to the row decoder, and 0x80–0xBF goes to the block decoder. No register holds any state.

Top module: `ed_page_decoder`

## Requirements
- R1: Codes 0x00–0x3F and 0xC0–0xFF give op_class 0 (NOP), with all other outputs at 0.
- R2: In 0x80–0xBF, a code with bit 5 = 1 and bit 2 = 0 gives op_class 17 (block), with blk_kind = bits 1:0 (0 load, 1 compare, 2 input, 3 output), blk_down = bit 3 and blk_repeat = bit 4. Every other code in that quadrant gives NOP.
- R3: Every code 0x44 + 8k (k = 0..7) gives op_class 7 (NEG).
- R4: Codes 0x4D, 0x5D, 0x6D and 0x7D give op_class 9 (RETI). Codes 0x45, 0x55, 0x65 and 0x75 give op_class 8 (RETN).
- R5: Codes 0x46 + 8k give op_class 10 with im_load = 1. The im_code values are: 00 for 0x46 and 0x66 (mode 0), 01 for 0x56 and 0x76 (mode 1), 10 for 0x5E and 0x7E (mode 2), and 11 for 0x4E and 0x6E (the undefined setting, which the interrupt logic treats as mode 0).
- R6: Code 0x70 gives op_class 1 (port input) with flag_only_in = 1, so the input value is written to no register. No other code raises flag_only_in.
- R7: Code 0x71 gives op_class 2 (port output) with const_out = 1. const_data is 0x00 when VARIANT = 0 (NMOS) and 0xFF when VARIANT = 1 (CMOS). No other code raises const_out.
- R8: Codes 0x40 + 8r give op_class 1 (port input) and codes 0x41 + 8r give op_class 2 (port output), with reg_sel = r (bits 5:3) in both cases.
- R9: Codes with bits 2:0 = 2 give op_class 3 (subtract-with-carry, 16 bit) when bit 3 = 0 and op_class 4 (add-with-carry) when bit 3 = 1. Codes with bits 2:0 = 3 give op_class 5 (store pair) when bit 3 = 0 and op_class 6 (load pair) when bit 3 = 1. In all of these, pair_sel = bits 5:4.
- R10: Codes 0x47, 0x4F, 0x57, 0x5F, 0x67 and 0x6F give op_class 11 through 16 in that order (I←A, R←A, A←I, A←R, RRD, RLD). Codes 0x77 and 0x7F give NOP.
- R11: Whenever a selector or control does not apply to the decoded class, it reads 0. This covers reg_sel, pair_sel, im_load, im_code, flag_only_in, const_out, const_data and the blk_* outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 8 | Byte following the extended-page prefix |
| op_class | output | 5 | Micro-operation class code |
| reg_sel | output | 3 | 8-bit register index for port I/O |
| pair_sel | output | 2 | Register pair index for 16-bit operations |
| im_load | output | 1 | Load the interrupt-mode latches |
| im_code | output | 2 | Interrupt-mode latch value |
| flag_only_in | output | 1 | Port input updates flags only |
| const_out | output | 1 | Port output drives const_data |
| const_data | output | 8 | Constant output value |
| blk_kind | output | 2 | Block operation kind |
| blk_down | output | 1 | Block address decrements |
| blk_repeat | output | 1 | Block operation repeats |

## Verification
At 0x70, the row decoder's port-input class and register index are active in the same evaluation as the port-special unit's flag-only control. At 0x71, the output class is active together with the constant-drive control and the variant-dependent value. The bench provokes both cases while sweeping all 256 codes, one per clock. It checks that every field of the output set matches a behavioural reference at the same time. A second instance, elaborated for the other variant, is driven with the same code so that both constant values are judged in the same cycle.

// File: rtl/ed_page_pkg.sv
package ed_page_pkg;

    localparam int OPC_W  = 8;
    localparam int DATA_W = 8;

    typedef enum logic [4:0] {
        OP_NOP    = 5'd0,
        OP_IN_C   = 5'd1,
        OP_OUT_C  = 5'd2,
        OP_SBC16  = 5'd3,
        OP_ADC16  = 5'd4,
        OP_ST16   = 5'd5,
        OP_LD16   = 5'd6,
        OP_NEG    = 5'd7,
        OP_RETN   = 5'd8,
        OP_RETI   = 5'd9,
        OP_IM     = 5'd10,
        OP_LD_I_A = 5'd11,
        OP_LD_R_A = 5'd12,
        OP_LD_A_I = 5'd13,
        OP_LD_A_R = 5'd14,
        OP_RRD    = 5'd15,
        OP_RLD    = 5'd16,
        OP_BLOCK  = 5'd17
    } ed_op_e;

    typedef enum logic [1:0] {
        IMC_MODE0 = 2'b00,
        IMC_MODE1 = 2'b01,
        IMC_MODE2 = 2'b10,
        IMC_UNDEF = 2'b11
    } im_code_e;

    // Row index bits 1:0 of the interrupt-mode column pick the latch value.
    function automatic im_code_e im_from_row(input logic [1:0] row_lo);
        im_code_e res;
        unique case (row_lo)
            2'd0:    res = IMC_MODE0;
            2'd1:    res = IMC_UNDEF;
            2'd2:    res = IMC_MODE1;
            default: res = IMC_MODE2;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/ed_quad_dec.sv
module ed_quad_dec
    import ed_page_pkg::*;
(
    input  logic [5:0] low_bits,
    output ed_op_e     op,
    output logic [2:0] reg_sel,
    output logic [1:0] pair_sel,
    output logic       im_load,
    output logic [1:0] im_code
);

    logic [2:0] col;
    logic [2:0] row;

    assign col = low_bits[2:0];
    assign row = low_bits[5:3];

    always_comb begin
        op       = OP_NOP;
        reg_sel  = '0;
        pair_sel = '0;
        im_load  = 1'b0;
        im_code  = '0;
        unique case (col)
            3'd0: begin
                op      = OP_IN_C;
                reg_sel = row;
            end
            3'd1: begin
                op      = OP_OUT_C;
                reg_sel = row;
            end
            3'd2: begin
                op       = row[0] ? OP_ADC16 : OP_SBC16;
                pair_sel = row[2:1];
            end
            3'd3: begin
                op       = row[0] ? OP_LD16 : OP_ST16;
                pair_sel = row[2:1];
            end
            3'd4: op = OP_NEG;
            3'd5: op = row[0] ? OP_RETI : OP_RETN;
            3'd6: begin
                op      = OP_IM;
                im_load = 1'b1;
                im_code = im_from_row(row[1:0]);
            end
            default: begin
                unique case (row)
                    3'd0:    op = OP_LD_I_A;
                    3'd1:    op = OP_LD_R_A;
                    3'd2:    op = OP_LD_A_I;
                    3'd3:    op = OP_LD_A_R;
                    3'd4:    op = OP_RRD;
                    3'd5:    op = OP_RLD;
                    default: op = OP_NOP;
                endcase
            end
        endcase
    end

    always_comb begin
        if (im_load) begin
            AST_IM_ONLY_IN_COL6: assert (col == 3'd6)
                else $error("im_load outside the mode column");   // R5
        end
    end

endmodule

// File: rtl/ed_blk_dec.sv
module ed_blk_dec (
    input  logic [5:0] low_bits,
    output logic       hit,
    output logic [1:0] kind,
    output logic       down,
    output logic       repeat_en
);

    always_comb begin
        hit       = low_bits[5] & ~low_bits[2];
        kind      = '0;
        down      = 1'b0;
        repeat_en = 1'b0;
        if (hit) begin
            kind      = low_bits[1:0];
            down      = low_bits[3];
            repeat_en = low_bits[4];
        end
    end

endmodule

// File: rtl/ed_port_special.sv
module ed_port_special #(
    parameter int VARIANT = 0,
    parameter int OPC_W   = 8,
    parameter int DATA_W  = 8
) (
    input  logic [OPC_W-1:0]  opcode,
    output logic              flag_only_in,
    output logic              const_out,
    output logic [DATA_W-1:0] const_data
);

    localparam logic [OPC_W-1:0] CODE_FLAG_IN = OPC_W'('h70);
    localparam logic [OPC_W-1:0] CODE_CONST   = OPC_W'('h71);

    logic [DATA_W-1:0] const_val;

    generate
        if (VARIANT != 0) begin : g_cmos
            assign const_val = '1;
        end else begin : g_nmos
            assign const_val = '0;
        end
    endgenerate

    assign flag_only_in = (opcode == CODE_FLAG_IN);
    assign const_out    = (opcode == CODE_CONST);
    assign const_data   = const_out ? const_val : '0;

endmodule

// File: rtl/ed_page_decoder.sv
module ed_page_decoder
    import ed_page_pkg::*;
#(
    parameter int VARIANT = 0
) (
    input  logic [7:0] opcode,
    output logic [4:0] op_class,
    output logic [2:0] reg_sel,
    output logic [1:0] pair_sel,
    output logic       im_load,
    output logic [1:0] im_code,
    output logic       flag_only_in,
    output logic       const_out,
    output logic [7:0] const_data,
    output logic [1:0] blk_kind,
    output logic       blk_down,
    output logic       blk_repeat
);

    localparam logic [7:0] CONST_EXP = (VARIANT != 0) ? 8'hFF : 8'h00;

    ed_op_e     q_op;
    logic [2:0] q_reg;
    logic [1:0] q_pair;
    logic       q_im_load;
    logic [1:0] q_im_code;
    logic       b_hit;
    logic [1:0] b_kind;
    logic       b_down;
    logic       b_rep;
    ed_op_e     sel_op;

    ed_quad_dec u_quad (
        .low_bits (opcode[5:0]),
        .op       (q_op),
        .reg_sel  (q_reg),
        .pair_sel (q_pair),
        .im_load  (q_im_load),
        .im_code  (q_im_code)
    );

    ed_blk_dec u_blk (
        .low_bits  (opcode[5:0]),
        .hit       (b_hit),
        .kind      (b_kind),
        .down      (b_down),
        .repeat_en (b_rep)
    );

    ed_port_special #(
        .VARIANT (VARIANT),
        .OPC_W   (OPC_W),
        .DATA_W  (DATA_W)
    ) u_port (
        .opcode       (opcode),
        .flag_only_in (flag_only_in),
        .const_out    (const_out),
        .const_data   (const_data)
    );

    always_comb begin
        sel_op     = OP_NOP;
        reg_sel    = '0;
        pair_sel   = '0;
        im_load    = 1'b0;
        im_code    = '0;
        blk_kind   = '0;
        blk_down   = 1'b0;
        blk_repeat = 1'b0;
        unique case (opcode[7:6])
            2'b01: begin
                sel_op   = q_op;
                reg_sel  = q_reg;
                pair_sel = q_pair;
                im_load  = q_im_load;
                im_code  = q_im_code;
            end
            2'b10: begin
                if (b_hit) begin
                    sel_op     = OP_BLOCK;
                    blk_kind   = b_kind;
                    blk_down   = b_down;
                    blk_repeat = b_rep;
                end
            end
            default: sel_op = OP_NOP;
        endcase
    end

    assign op_class = sel_op;

    always_comb begin
        if (opcode[7:6] == 2'b00 || opcode[7:6] == 2'b11) begin
            AST_OUTER_IS_NOP: assert (op_class == OP_NOP && !im_load && !flag_only_in && !const_out)
                else $error("outer quadrant not NOP");   // R1
        end
        if (op_class == OP_BLOCK) begin
            AST_BLOCK_QUADRANT: assert (opcode[7:5] == 3'b101)
                else $error("block class outside its range");   // R2
        end
        if (im_load) begin
            AST_IM_CLASS: assert (op_class == OP_IM)
                else $error("mode load without mode class");   // R5
        end
        if (flag_only_in) begin
            AST_FLAG_IN_CLASS: assert (op_class == OP_IN_C && reg_sel == 3'd6)
                else $error("flag-only input on wrong class");   // R6
        end
        if (const_out) begin
            AST_CONST_VALUE: assert (op_class == OP_OUT_C && const_data == CONST_EXP)
                else $error("constant output wrong");   // R7
        end
    end

endmodule

// File: tb/ed_page_decoder_tb.sv
module ed_page_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opcode = 8'h00;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    logic [4:0] op_class, op_class_c;
    logic [2:0] reg_sel, reg_sel_c;
    logic [1:0] pair_sel, pair_sel_c;
    logic       im_load, im_load_c;
    logic [1:0] im_code, im_code_c;
    logic       flag_only_in, flag_only_in_c;
    logic       const_out, const_out_c;
    logic [7:0] const_data, const_data_c;
    logic [1:0] blk_kind, blk_kind_c;
    logic       blk_down, blk_down_c;
    logic       blk_repeat, blk_repeat_c;

    always #5 clk = ~clk;

    ed_page_decoder #(.VARIANT(0)) u_dut (
        .opcode(opcode), .op_class(op_class), .reg_sel(reg_sel), .pair_sel(pair_sel),
        .im_load(im_load), .im_code(im_code), .flag_only_in(flag_only_in),
        .const_out(const_out), .const_data(const_data), .blk_kind(blk_kind),
        .blk_down(blk_down), .blk_repeat(blk_repeat)
    );

    ed_page_decoder #(.VARIANT(1)) u_dut_cmos (
        .opcode(opcode), .op_class(op_class_c), .reg_sel(reg_sel_c), .pair_sel(pair_sel_c),
        .im_load(im_load_c), .im_code(im_code_c), .flag_only_in(flag_only_in_c),
        .const_out(const_out_c), .const_data(const_data_c), .blk_kind(blk_kind_c),
        .blk_down(blk_down_c), .blk_repeat(blk_repeat_c)
    );

    int neg_q[$]  = '{'h44, 'h4C, 'h54, 'h5C, 'h64, 'h6C, 'h74, 'h7C};
    int reti_q[$] = '{'h4D, 'h5D, 'h6D, 'h7D};
    int retn_q[$] = '{'h45, 'h55, 'h65, 'h75};
    int spec_q[$] = '{'h47, 'h4F, 'h57, 'h5F, 'h67, 'h6F};

    task automatic chk(string req, int code, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s code=%02h actual=%0d expected=%0d", req, code, act, exp);
        end
    endtask

    function automatic bit in_q(int q[$], int c);
        foreach (q[i]) if (q[i] == c) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int ref_op(int c);
        int lo = c % 8;
        int mid = (c / 8) % 8;
        if (c < 64 || c >= 192) return 0;
        if (c >= 128) return (c >= 'hA0 && lo < 4) ? 17 : 0;
        if (in_q(neg_q, c)) return 7;
        if (in_q(reti_q, c)) return 9;
        if (in_q(retn_q, c)) return 8;
        for (int i = 0; i < spec_q.size(); i++) if (spec_q[i] == c) return 11 + i;
        if (c == 'h77 || c == 'h7F) return 0;
        if (lo == 6) return 10;
        if (lo == 0) return 1;
        if (lo == 1) return 2;
        if (lo == 2) return (mid % 2 == 1) ? 4 : 3;
        return (mid % 2 == 1) ? 6 : 5;
    endfunction

    function automatic string ref_tag(int c);
        int lo = c % 8;
        if (c < 64 || c >= 192) return "R1";
        if (c >= 128) return "R2";
        if (c == 'h70) return "R6";
        if (c == 'h71) return "R7";
        if (lo == 4) return "R3";
        if (lo == 5) return "R4";
        if (lo == 6) return "R5";
        if (lo < 2) return "R8";
        if (lo < 4) return "R9";
        return "R10";
    endfunction

    function automatic int ref_im(int c);
        case (c)
            'h46, 'h66: return 0;
            'h56, 'h76: return 1;
            'h5E, 'h7E: return 2;
            'h4E, 'h6E: return 3;
            default:    return 0;
        endcase
    endfunction

    task automatic check_code(int c);
        int e_op = ref_op(c);
        bit is_io = (e_op == 1 || e_op == 2);
        bit is_16 = (e_op >= 3 && e_op <= 6);
        bit is_blk = (e_op == 17);
        string t = ref_tag(c);
        chk(t, c, op_class, e_op);
        chk(is_io ? "R8" : "R11", c, reg_sel, is_io ? (c / 8) % 8 : 0);
        chk(is_16 ? "R9" : "R11", c, pair_sel, is_16 ? (c / 16) % 4 : 0);
        chk(e_op == 10 ? "R5" : "R11", c, im_load, e_op == 10);
        chk(e_op == 10 ? "R5" : "R11", c, im_code, ref_im(c));
        chk(c == 'h70 ? "R6" : "R11", c, flag_only_in, c == 'h70);
        chk(c == 'h71 ? "R7" : "R11", c, const_out, c == 'h71);
        chk(c == 'h71 ? "R7" : "R11", c, const_data, 0);
        chk(c == 'h71 ? "R7" : "R11", c, const_data_c, c == 'h71 ? 255 : 0);
        chk(c == 'h71 ? "R7" : "R11", c, const_out_c, c == 'h71);
        chk(is_blk ? "R2" : "R11", c, blk_kind, is_blk ? c % 4 : 0);
        chk(is_blk ? "R2" : "R11", c, blk_down, is_blk ? (c / 8) % 2 : 0);
        chk(is_blk ? "R2" : "R11", c, blk_repeat, is_blk ? (c / 16) % 2 : 0);
        chk(t, c, op_class_c, e_op);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11", 0, op_class, 0);          // reset state: code 0x00 decodes as NOP
        chk("R11", 0, im_load, 0);
        rst_n = 1'b1;
        for (int c = 0; c < 256; c++) begin
            @(posedge clk);
            opcode = 8'(c);
            @(negedge clk);
            check_code(c);
        end
        // explicit corner codes: R6 flag-only input with reg index 6, R7 constant
        @(posedge clk); opcode = 8'h70; @(negedge clk);
        chk("R6", 'h70, reg_sel, 6);
        chk("R6", 'h70, flag_only_in, 1);
        @(posedge clk); opcode = 8'h71; @(negedge clk);
        chk("R7", 'h71, const_data, 'h00);
        chk("R7", 'h71, const_data_c, 'hFF);
        @(posedge clk); opcode = 8'h4E; @(negedge clk);
        chk("R5", 'h4E, im_code, 3);
        @(posedge clk); opcode = 8'hBB; @(negedge clk);
        chk("R2", 'hBB, op_class, 17);
        @(posedge clk); opcode = 8'hA4; @(negedge clk);
        chk("R2", 'hA4, op_class, 0);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule